// File: doc/BRIEF.md
# Multi-mode timer base counter

This block is the time base of a general-purpose timer. A prescaler divides the clock into counting ticks, and a counter steps through a programmable period on each tick. The counter can count up, count down, or run in one of three center-aligned variants that climb to the top and fall back to zero. The three variants differ only in which turnaround raises an update event.

A repetition down-counter holds back update events until a programmed number of periods has passed. Software can force an update at any time. Each update is a one-cycle pulse and also sets a sticky flag that stays high until it is cleared. The period can be taken directly from the input or through a shadow copy that loads only at update events. In one-shot operation the counter halts after its first update. Start and stop are single-cycle pulses, and a clear command puts the count back to its starting point.

Top module: `tbase_counter`

## Requirements
- R1: Counting ticks occur once every `psc_in`+1 clock cycles while the counter runs. The first tick falls in the cycle after the start pulse is registered.
- R2: Mode code 0 (up): on each tick the count rises by one. A tick at a count equal to or above the period returns the count to 0 and raises an update candidate.
- R3: Mode code 1 (down): on each tick the count falls by one. A tick at count 0 reloads the period and raises an update candidate. `dir_down` reads 1 in this mode.
- R4: Mode codes 2, 3 and 4 (center): the count climbs 0,1,…,period-1 and then turns at the period value. It then falls back to 0 and turns upward again. `dir_down` is 1 during the falling half and 0 during the rising half.
- R5: Center code 2 raises the update candidate only at the bottom turnaround. Code 3 raises it only at the top turnaround. Code 4 raises it at both.
- R6: An update candidate becomes an update only when `rep_left` is 0, and `rep_left` then reloads from `rep_in`. Otherwise `rep_left` falls by one and no update is issued.
- R7: With `one_shot`=1 the counter stops after its first update and holds its count. With `one_shot`=0 it keeps running.
- R8: With `preload_en`=1, a new `period_in` takes effect only after the next update. With `preload_en`=0 it takes effect on the next tick.
- R9: A `sw_update` pulse produces an update one cycle later regardless of `rep_left`, and reloads `rep_left` from `rep_in`.
- R10: `update_pulse` is high for one cycle per update. `update_flag` sets with it and holds until `flag_clr`. When a set and a clear fall in the same cycle, the set wins.
- R11: A `stop` pulse freezes the count without altering it, and `stop` overrides a simultaneous `start`. `cnt_clear` forces the count to 0 in up and center modes and to the period in down mode, and it takes precedence over a tick.
- R12: After reset the count, `dir_down`, `update_pulse`, `update_flag` and `rep_left` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: begin counting |
| stop | input | 1 | Pulse: halt counting, count kept |
| cnt_clear | input | 1 | Pulse: return count to its starting value |
| sw_update | input | 1 | Pulse: force an update event |
| flag_clr | input | 1 | Pulse: clear the sticky update flag |
| mode | input | 3 | 0 up, 1 down, 2/3/4 center (bottom/top/both) |
| one_shot | input | 1 | Stop after the first update |
| preload_en | input | 1 | Period goes through the shadow copy |
| psc_in | input | PSC_W | Prescaler value; tick rate is clock/(psc_in+1) |
| period_in | input | CNT_W | Counting period |
| rep_in | input | REP_W | Repetition reload value |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | 1 while counting downward |
| update_pulse | output | 1 | One-cycle update event |
| update_flag | output | 1 | Sticky update status |
| rep_left | output | REP_W | Periods still to run before the next update |

## Verification
Two collisions are provoked on purpose. In the first, a software update and a flag clear are driven in the same cycle. The bench then judges that the flag reads set in the next cycle, and that it falls only after a later lone clear. In the second, a clear command is issued in a cycle that also carries a counting tick. Its result is judged by the count showing the mode's start value rather than the stepped value. Scenarios run through a reference sequence computed in the bench from the mode rules. This sequence predicts count, direction, repetition value and update pulse for every cycle after the start.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [2:0] {
    TB_UP       = 3'd0,
    TB_DOWN     = 3'd1,
    TB_CTR_BOT  = 3'd2,
    TB_CTR_TOP  = 3'd3,
    TB_CTR_BOTH = 3'd4
  } tb_mode_e;
endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] div_q, div_d;
  logic             at_end;

  assign at_end = (div_q >= psc);

  always_comb begin
    div_d = div_q;
    if (!run || clr)  div_d = '0;
    else if (at_end)  div_d = '0;
    else              div_d = div_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R1: one tick per psc+1 cycles while running
  assign tick = run & at_end;
endmodule

// File: rtl/tbase_core.sv
module tbase_core
  import tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             hw_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  tb_mode_e         mode_e;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d, hit;
  logic [CNT_W:0]   inc_w;
  logic             top_turn, bot_turn;

  assign mode_e   = tb_mode_e'(mode);
  assign inc_w    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign top_turn = (inc_w >= {1'b0, period});
  assign bot_turn = (cnt_q <= ONE);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    hit   = 1'b0;
    if (clr) begin
      // R11: clear wins over a tick
      if (mode_e == TB_DOWN) begin
        cnt_d = period;
        dir_d = 1'b1;
      end else begin
        cnt_d = '0;
        dir_d = 1'b0;
      end
    end else if (tick) begin
      case (mode_e)
        TB_DOWN: begin
          dir_d = 1'b1;
          if (cnt_q == '0) begin
            cnt_d = period;
            hit   = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        TB_CTR_BOT, TB_CTR_TOP, TB_CTR_BOTH: begin
          if (!dir_q) begin
            if (top_turn) begin
              cnt_d = period;
              dir_d = 1'b1;
              hit   = (mode_e != TB_CTR_BOT);
            end else begin
              cnt_d = inc_w[CNT_W-1:0];
            end
          end else begin
            if (bot_turn) begin
              cnt_d = '0;
              dir_d = 1'b0;
              hit   = (mode_e != TB_CTR_TOP);
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: begin
          dir_d = 1'b0;
          if (cnt_q >= period) begin
            cnt_d = '0;
            hit   = 1'b1;
          end else begin
            cnt_d = inc_w[CNT_W-1:0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign count    = cnt_q;
  assign dir_down = dir_q;
  assign hw_evt   = hit;
endmodule

// File: rtl/tbase_repgate.sv
module tbase_repgate #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_evt,
  input  logic             sw_upd,
  input  logic             flag_clr,
  input  logic [REP_W-1:0] rep_in,
  output logic             upd_now,
  output logic             update_pulse,
  output logic             update_flag,
  output logic [REP_W-1:0] rep_left
);
  logic [REP_W-1:0] rep_q, rep_d;
  logic             pulse_q, flag_q, flag_d;

  // R6, R9: gate hardware candidates by the repetition count
  assign upd_now = sw_upd | (hw_evt & (rep_q == '0));

  always_comb begin
    rep_d = rep_q;
    if (upd_now)     rep_d = rep_in;
    else if (hw_evt) rep_d = rep_q - REP_W'(1);
    // R10: set beats clear
    flag_d = upd_now | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q   <= '0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      rep_q   <= rep_d;
      pulse_q <= upd_now;
      flag_q  <= flag_d;
    end
  end

  assign update_pulse = pulse_q;
  assign update_flag  = flag_q;
  assign rep_left     = rep_q;
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cnt_clear,
  input  logic             sw_update,
  input  logic             flag_clr,
  input  logic [2:0]       mode,
  input  logic             one_shot,
  input  logic             preload_en,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] period_in,
  input  logic [REP_W-1:0] rep_in,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             update_pulse,
  output logic             update_flag,
  output logic [REP_W-1:0] rep_left
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             run_q, run_d;
  logic [CNT_W-1:0] shadow_q, shadow_d, eff_per;
  logic             tick, hw_evt, upd_now;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    run_d = run_q;
    if (stop)                             run_d = 1'b0;   // R11
    else if (run_q && one_shot && upd_now) run_d = 1'b0;  // R7
    else if (start)                       run_d = 1'b1;
    // R8: shadow follows the input while idle or at an update
    shadow_d = (upd_now || !run_q) ? period_in : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      run_q    <= run_d;
      shadow_q <= shadow_d;
    end
  end

  assign eff_per = preload_en ? shadow_q : period_in;

  tbase_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (run_q),
    .clr  (cnt_clear),
    .psc  (psc_in),
    .tick (tick)
  );

  tbase_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .clr     (cnt_clear),
    .mode    (mode),
    .period  (eff_per),
    .count   (count),
    .dir_down(dir_down),
    .hw_evt  (hw_evt)
  );

  tbase_repgate #(.REP_W(REP_W)) u_rep (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .hw_evt      (hw_evt),
    .sw_upd      (sw_update),
    .flag_clr    (flag_clr),
    .rep_in      (rep_in),
    .upd_now     (upd_now),
    .update_pulse(update_pulse),
    .update_flag (update_flag),
    .rep_left    (rep_left)
  );
endmodule

// File: rtl/tbase_counter_chk.sv
module tbase_counter_chk #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop,
  input logic             cnt_clear,
  input logic             flag_clr,
  input logic [2:0]       mode,
  input logic [REP_W-1:0] rep_in,
  input logic [CNT_W-1:0] count,
  input logic             update_pulse,
  input logic             update_flag,
  input logic [REP_W-1:0] rep_left
);
  // R10
  flag_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> update_flag);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_flag && !flag_clr) |=> update_flag);

  // R6
  rep_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> (rep_left == $past(rep_in)));

  // R11
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> ##2 ($stable(count) || $past(cnt_clear)));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !cnt_clear) |=>
      (count == CNT_W'($past(count) + CNT_W'(1)) || count == '0 || $stable(count)));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !cnt_clear && count != '0) |=>
      (count == CNT_W'($past(count) - CNT_W'(1)) || $stable(count)));
endmodule

bind tbase_counter tbase_counter_chk #(.CNT_W(CNT_W), .REP_W(REP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop        (stop),
  .cnt_clear   (cnt_clear),
  .flag_clr    (flag_clr),
  .mode        (mode),
  .rep_in      (rep_in),
  .count       (count),
  .update_pulse(update_pulse),
  .update_flag (update_flag),
  .rep_left    (rep_left)
);

// File: tb/tb_tbase_counter.sv
module tb_tbase_counter;
  localparam int CW = 16;
  localparam int PW = 16;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start, stop, cnt_clear, sw_update, flag_clr;
  logic [2:0] mode;
  logic one_shot, preload_en;
  logic [PW-1:0] psc_in;
  logic [CW-1:0] period_in;
  logic [RW-1:0] rep_in;
  logic [CW-1:0] count;
  logic dir_down, update_pulse, update_flag;
  logic [RW-1:0] rep_left;

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct {
    int    cyc;
    int    cnt;
    bit    upd;
    bit    dir;
    int    rep;
    string tag;
  } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  tbase_counter #(.CNT_W(CW), .PSC_W(PW), .REP_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cnt_clear(cnt_clear),
    .sw_update(sw_update), .flag_clr(flag_clr), .mode(mode), .one_shot(one_shot),
    .preload_en(preload_en), .psc_in(psc_in), .period_in(period_in), .rep_in(rep_in),
    .count(count), .dir_down(dir_down), .update_pulse(update_pulse),
    .update_flag(update_flag), .rep_left(rep_left)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      mon_e = sbq.pop_front();
      check(mon_e.cyc == cyc, mon_e.tag, "missed sample cycle", cyc, mon_e.cyc);
      check(int'(count) == mon_e.cnt, mon_e.tag, "count", int'(count), mon_e.cnt);
      check(update_pulse == mon_e.upd, mon_e.tag, "update_pulse", int'(update_pulse), int'(mon_e.upd));
      check(dir_down == mon_e.dir, mon_e.tag, "dir_down", int'(dir_down), int'(mon_e.dir));
      check(int'(rep_left) == mon_e.rep, mon_e.tag, "rep_left", int'(rep_left), mon_e.rep);
    end
  end

  task automatic push(input int c, input int cn, input bit u, input bit d, input int r,
                      input string tag);
    exp_t e;
    e.cyc = c; e.cnt = cn; e.upd = u; e.dir = d; e.rep = r; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic drain();
    wait (sbq.size() == 0);
    @(negedge clk);
  endtask

  // program, clear and start; predict ncyc cycles from the requirements
  task automatic run_model(input int md, input int p, input int psc, input int rep,
                           input bit os, input bit pre, input int ncyc,
                           input string tag, output int s);
    int r_cnt, r_rep, ph;
    bit r_dir, r_run, r_upd, tk, ev;
    @(negedge clk);
    mode = 3'(md); period_in = CW'(p); psc_in = PW'(psc); rep_in = RW'(rep);
    one_shot = os; preload_en = pre; stop = 1'b1; sw_update = 1'b1;
    @(negedge clk);
    stop = 1'b0; sw_update = 1'b0; flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0; cnt_clear = 1'b1; start = 1'b1;
    s = cyc;
    r_cnt = (md == 1) ? p : 0;
    r_dir = (md == 1);
    r_rep = rep; r_run = 1'b1; r_upd = 1'b0; ph = 0;
    for (int t = s + 1; t <= s + ncyc; t++) begin
      push(t, r_cnt, r_upd, r_dir, r_rep, tag);
      r_upd = 1'b0;
      if (r_run) begin
        tk = (ph == psc);
        ph = tk ? 0 : ph + 1;
        if (tk) begin
          ev = 1'b0;
          if (md == 1) begin
            if (r_cnt == 0) begin r_cnt = p; ev = 1'b1; end else r_cnt--;
          end else if (md >= 2) begin
            if (!r_dir) begin
              if (r_cnt + 1 >= p) begin r_cnt = p; r_dir = 1'b1; ev = (md != 2); end
              else r_cnt++;
            end else begin
              if (r_cnt <= 1) begin r_cnt = 0; r_dir = 1'b0; ev = (md != 3); end
              else r_cnt--;
            end
          end else begin
            if (r_cnt >= p) begin r_cnt = 0; ev = 1'b1; end else r_cnt++;
          end
          if (ev) begin
            if (r_rep == 0) begin
              r_upd = 1'b1; r_rep = rep;
              if (os) r_run = 1'b0;
            end else r_rep--;
          end
        end
      end
    end
    @(negedge clk);
    cnt_clear = 1'b0; start = 1'b0;
    drain();
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int s, c1;
    rst_n = 1'b0;
    start = 0; stop = 0; cnt_clear = 0; sw_update = 0; flag_clr = 0;
    mode = 3'd0; one_shot = 0; preload_en = 0;
    psc_in = '0; period_in = '0; rep_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check(count == '0, "R12", "count", int'(count), 0);
    check(dir_down == 1'b0, "R12", "dir_down", int'(dir_down), 0);
    check(update_pulse == 1'b0, "R12", "update_pulse", int'(update_pulse), 0);
    check(update_flag == 1'b0, "R12", "update_flag", int'(update_flag), 0);
    check(rep_left == '0, "R12", "rep_left", int'(rep_left), 0);

    run_model(0, 3, 0, 0, 0, 1, 14, "R2 up", s);
    run_model(1, 4, 1, 0, 0, 1, 24, "R1 R3 down psc=1", s);
    run_model(0, 2, 2, 0, 0, 1, 24, "R1 up psc=2", s);
    run_model(2, 3, 0, 0, 0, 1, 20, "R4 R5 center bottom", s);
    run_model(3, 3, 0, 0, 0, 1, 20, "R4 R5 center top", s);
    run_model(4, 4, 0, 0, 0, 1, 24, "R4 R5 center both", s);
    run_model(0, 2, 0, 2, 0, 1, 30, "R6 repetition up", s);
    run_model(4, 2, 0, 1, 0, 1, 30, "R6 repetition center", s);
    run_model(0, 3, 0, 1, 1, 1, 20, "R7 one-shot up", s);
    run_model(1, 2, 0, 0, 1, 1, 12, "R7 one-shot down", s);

    // R8 preloaded period: change at count 1, old period completes first
    run_model(0, 9, 0, 0, 0, 1, 0, "R8", s);
    period_in = CW'(5);
    push(s + 10, 9, 0, 0, 0, "R8 preload old period");
    push(s + 11, 0, 1, 0, 0, "R8 preload wrap");
    push(s + 16, 5, 0, 0, 0, "R8 preload new period");
    push(s + 17, 0, 1, 0, 0, "R8 preload second wrap");
    drain();

    // R8 immediate period
    run_model(0, 9, 0, 0, 0, 0, 0, "R8", s);
    period_in = CW'(5);
    push(s + 6, 5, 0, 0, 0, "R8 immediate top");
    push(s + 7, 0, 1, 0, 0, "R8 immediate wrap");
    drain();

    // R11 stop freezes, start resumes, stop beats start, clear values
    run_model(0, 7, 0, 0, 0, 1, 0, "R11", s);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    c1 = int'(count);
    repeat (3) @(negedge clk);
    check(int'(count) == c1, "R11 stop freeze", "count", int'(count), c1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(int'(count) == ((c1 == 7) ? 0 : c1 + 1), "R11 restart", "count",
          int'(count), (c1 == 7) ? 0 : c1 + 1);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    c1 = int'(count);
    start = 1'b1; stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(count) == c1, "R11 stop over start", "count", int'(count), c1);
    mode = 3'd1; cnt_clear = 1'b1;
    @(negedge clk); cnt_clear = 1'b0;
    check(int'(count) == 7, "R11 clear down", "count", int'(count), 7);
    check(dir_down == 1'b1, "R11 clear down", "dir_down", int'(dir_down), 1);
    // R11 clear coincident with a tick in up mode
    mode = 3'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    cnt_clear = 1'b1;
    @(negedge clk); cnt_clear = 1'b0;
    check(count == '0, "R11 clear beats tick", "count", int'(count), 0);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;

    // R9 / R10 software update with simultaneous flag clear
    @(negedge clk);
    rep_in = RW'(7); sw_update = 1'b1; flag_clr = 1'b1;
    @(negedge clk); sw_update = 1'b0; flag_clr = 1'b0;
    check(update_pulse == 1'b1, "R9 sw update", "update_pulse", int'(update_pulse), 1);
    check(int'(rep_left) == 7, "R9 sw update", "rep_left", int'(rep_left), 7);
    check(update_flag == 1'b1, "R10 set beats clear", "update_flag", int'(update_flag), 1);
    @(negedge clk);
    check(update_pulse == 1'b0, "R10 pulse width", "update_pulse", int'(update_pulse), 0);
    check(update_flag == 1'b1, "R10 sticky", "update_flag", int'(update_flag), 1);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check(update_flag == 1'b0, "R10 clear", "update_flag", int'(update_flag), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule